// File: doc/BRIEF.md
# Dual-Direction Universal Bus Register

This block moves a data word between two ports, A and B, in either direction. Each direction has its own storage cell. A latch-enable input per direction selects how that cell behaves. When the latch enable is high the path is transparent and the output follows the input with no clock delay. When the latch enable is low the output shows the stored word, which is reloaded on every rising edge of the shared clock.

The word is split into two byte halves. Each half has its own pair of latch enables and its own pair of active-low output enables. One clock serves every path. A global active-low output enable, when high, turns off every driver on both ports.

Drivers are not modelled as tri-state nets. Each port presents its data on a plain output. A separate drive-enable output per half tells the pad ring or an enclosing tri-state wrapper when to drive that data onto the bus.

Top module: `dual_dir_bus_reg`

## Requirements
- R1: With `le_ab[h]` high, the B-side data of half h (bits 8h+7..8h) equals the A-side input of that half in the same cycle, with no clock edge needed.
- R2: With `le_ab[h]` low and no rising clock edge, the B-side data of half h stays constant while the A input changes.
- R3: With `le_ab[h]` low, after a rising clock edge the B-side data of half h equals the A input sampled at that edge.
- R4: `b_drv_en[h]` is 1 only when `oe_ab_n[h]` is 0. A 1 on `oe_ab_n[h]` puts half h of the B side in the non-driving state.
- R5: The B-to-A path follows R1 to R4 with `le_ba`, `oe_ba_n`, `b_in`, `a_out` and `a_drv_en` in place of the A-to-B signals.
- R6: When `oe_all_n` is 1, all four drive enables are 0 whatever the per-half output enables are. When it is 0, the per-half enables decide.
- R7: Half 0 (bits 7..0) is governed only by control index 0, and half 1 (bits 15..8) only by index 1. A change on one half's controls or data leaves the other half's outputs unchanged.
- R8: The reset is synchronous and active low. A rising edge with `rst_n` at 0 clears every storage cell to zero. While `rst_n` is 0, every drive enable is 0.
- R9: A storage cell also loads on each rising edge while its path is transparent. When the latch enable then falls, the output shows the input sampled at the last rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; storage loads on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | Data arriving from the A port |
| b_in | input | 16 | Data arriving from the B port |
| le_ab | input | 2 | Per-half A-to-B latch enable, high = transparent |
| le_ba | input | 2 | Per-half B-to-A latch enable, high = transparent |
| oe_ab_n | input | 2 | Per-half A-to-B output enable, active low |
| oe_ba_n | input | 2 | Per-half B-to-A output enable, active low |
| oe_all_n | input | 1 | Global output enable, active low, overrides all halves |
| b_out | output | 16 | Data to present on the B port |
| b_drv_en | output | 2 | Per-half drive enable for the B port |
| a_out | output | 16 | Data to present on the A port |
| a_drv_en | output | 2 | Per-half drive enable for the A port |

## Verification
A corrupted storage cell shows up on the opposite port as soon as its latch enable is low, and stays visible until the next rising edge overwrites it. Bench stimulus therefore changes data and latch enables at random, and the outputs are compared against a bench model after every edge and every input change. Stopping the clock exposes a cell that loads without an edge. Changing one half while the other holds exposes any crossed control. A faulty drive-enable term shows up at once, because that path has no register between the enables and the outputs.

// File: rtl/dbr_pkg.sv
// Package: shared sizing defaults and the per-half control bundle.
// Assumes: every half carries the same set of four control bits.
package dbr_pkg;
    localparam int unsigned DBR_HALF_W_DEF = 8;
    localparam int unsigned DBR_HALVES_DEF = 2;

    // Control bits that steer one half of the word.
    typedef struct packed {
        logic le_ab;
        logic le_ba;
        logic oe_ab_n;
        logic oe_ba_n;
    } dbr_ctl_t;
endpackage

// File: rtl/dbr_path_cell.sv
// Module: one direction's storage cell for one half.
// Loads the input on every rising clock edge. The output shows the live
// input while le is high and the stored word while le is low.
// Assumes: synchronous active-low reset clears the store.
module dbr_path_cell #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         le,
    output logic [W-1:0] q
);
    logic [W-1:0] store;

    // Store: clear on reset, otherwise load the input every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) store <= '0;
        else        store <= d;
    end

    // Output select: transparent pass or stored word.
    always_comb begin
        q = le ? d : store;
    end
endmodule

// File: rtl/dbr_drive_ctl.sv
// Module: drive-enable decision for one direction of one half.
// Assumes: both enables are active low and reset forces the drivers off.
module dbr_drive_ctl (
    input  logic rst_n,
    input  logic oe_all_n,
    input  logic oe_n,
    output logic drv_en
);
    // Drive only outside reset with the global and local enables both asserted.
    always_comb begin
        drv_en = rst_n & ~oe_all_n & ~oe_n;
    end
endmodule

// File: rtl/dbr_half_lane.sv
// Module: one half of the word, holding both directions of storage and
// drive control.
// Assumes: the controls come bundled as dbr_ctl_t.
module dbr_half_lane
    import dbr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  dbr_ctl_t     ctl,
    input  logic         oe_all_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] a_out,
    output logic         b_drv_en,
    output logic         a_drv_en
);
    dbr_path_cell #(.W(W)) u_cell_ab (
        .clk(clk), .rst_n(rst_n), .d(a_in), .le(ctl.le_ab), .q(b_out)
    );

    dbr_path_cell #(.W(W)) u_cell_ba (
        .clk(clk), .rst_n(rst_n), .d(b_in), .le(ctl.le_ba), .q(a_out)
    );

    dbr_drive_ctl u_drv_b (
        .rst_n(rst_n), .oe_all_n(oe_all_n), .oe_n(ctl.oe_ab_n), .drv_en(b_drv_en)
    );

    dbr_drive_ctl u_drv_a (
        .rst_n(rst_n), .oe_all_n(oe_all_n), .oe_n(ctl.oe_ba_n), .drv_en(a_drv_en)
    );
endmodule

// File: rtl/dual_dir_bus_reg.sv
// Module: top of the two-direction bus register, split into halves.
// Assumes: one shared clock, synchronous active-low reset. Drivers are
// presented as data plus drive enable for an outer pad or tri-state wrapper.
module dual_dir_bus_reg
    import dbr_pkg::*;
#(
    parameter int unsigned HALF_W = DBR_HALF_W_DEF,
    parameter int unsigned HALVES = DBR_HALVES_DEF,
    localparam int unsigned DATA_W = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [HALVES-1:0] le_ab,
    input  logic [HALVES-1:0] le_ba,
    input  logic [HALVES-1:0] oe_ab_n,
    input  logic [HALVES-1:0] oe_ba_n,
    input  logic              oe_all_n,
    output logic [DATA_W-1:0] b_out,
    output logic [HALVES-1:0] b_drv_en,
    output logic [DATA_W-1:0] a_out,
    output logic [HALVES-1:0] a_drv_en
);
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        dbr_ctl_t ctl;

        // Bundle this half's control bits.
        always_comb begin
            ctl.le_ab   = le_ab[g];
            ctl.le_ba   = le_ba[g];
            ctl.oe_ab_n = oe_ab_n[g];
            ctl.oe_ba_n = oe_ba_n[g];
        end

        dbr_half_lane #(.W(HALF_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (a_in[g*HALF_W +: HALF_W]),
            .b_in     (b_in[g*HALF_W +: HALF_W]),
            .ctl      (ctl),
            .oe_all_n (oe_all_n),
            .b_out    (b_out[g*HALF_W +: HALF_W]),
            .a_out    (a_out[g*HALF_W +: HALF_W]),
            .b_drv_en (b_drv_en[g]),
            .a_drv_en (a_drv_en[g])
        );

        // R3: a latched A-to-B half shows the A word from the previous edge.
        a_r3_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !le_ab[g]) |->
                b_out[g*HALF_W +: HALF_W] == $past(a_in[g*HALF_W +: HALF_W]));

        // R5: the same capture rule for B to A.
        a_r5_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !le_ba[g]) |->
                a_out[g*HALF_W +: HALF_W] == $past(b_in[g*HALF_W +: HALF_W]));

        // R4: a disabled direction never drives.
        a_r4_oe_off: assert property (@(posedge clk)
            oe_ab_n[g] |-> !b_drv_en[g]);

        // R6: the global enable overrides both directions.
        a_r6_global_off: assert property (@(posedge clk)
            oe_all_n |-> (!b_drv_en[g] && !a_drv_en[g]));
    end

    // R8: no driver is on during reset.
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (b_drv_en == '0 && a_drv_en == '0));
endmodule

// File: tb/dual_dir_bus_reg_bench.sv
module dual_dir_bus_reg_bench;
    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  le_ab = '0, le_ba = '0, oe_ab_n = '1, oe_ba_n = '1;
    logic        oe_all_n = 1'b1;
    logic [15:0] b_out, a_out;
    logic [1:0]  b_drv_en, a_drv_en;

    int checks = 0, failures = 0, contention = 0;
    logic [15:0] m_ab = '0, m_ba = '0;
    logic [15:0] snap;
    bit done = 1'b0;

    dual_dir_bus_reg u_dual_dir_bus_reg (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .le_ab(le_ab), .le_ba(le_ba), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
        .oe_all_n(oe_all_n), .b_out(b_out), .b_drv_en(b_drv_en),
        .a_out(a_out), .a_drv_en(a_drv_en)
    );

    // 50 MHz clock that can be paused in the low phase.
    always begin
        #10;
        if (clk_run) clk = ~clk;
    end

    // Reference storage: loads every edge, cleared in reset (R8, R9).
    always @(posedge clk) begin
        m_ab <= rst_n ? a_in : 16'h0;
        m_ba <= rst_n ? b_in : 16'h0;
    end

    function automatic logic [7:0] exp_data(logic le, logic [7:0] live, logic [7:0] st);
        return le ? live : st;
    endfunction

    function automatic logic exp_drv(logic rn, logic all_n, logic oe_n);
        return rn & ~all_n & ~oe_n;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the reference model.
    task automatic check_all();
        for (int h = 0; h < 2; h++) begin
            chk(le_ab[h] ? "R1" : "R3", {8'h0, b_out[h*8 +: 8]},
                {8'h0, exp_data(le_ab[h], a_in[h*8 +: 8], m_ab[h*8 +: 8])});
            chk("R5", {8'h0, a_out[h*8 +: 8]},
                {8'h0, exp_data(le_ba[h], b_in[h*8 +: 8], m_ba[h*8 +: 8])});
            chk(oe_all_n ? "R6" : "R4", {15'h0, b_drv_en[h]},
                {15'h0, exp_drv(rst_n, oe_all_n, oe_ab_n[h])});
            chk(oe_all_n ? "R6" : "R5", {15'h0, a_drv_en[h]},
                {15'h0, exp_drv(rst_n, oe_all_n, oe_ba_n[h])});
            if (a_drv_en[h] && b_drv_en[h]) contention++;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R8: reset clears the storage and holds the drivers off.
        oe_ab_n = 2'b00; oe_ba_n = 2'b00; oe_all_n = 1'b0;
        a_in = 16'hdead; b_in = 16'hbeef;
        repeat (3) @(negedge clk);
        chk("R8", b_out, 16'h0);
        chk("R8", a_out, 16'h0);
        chk("R8", {14'h0, b_drv_en}, 16'h0);
        chk("R8", {14'h0, a_drv_en}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_all();

        // R1: transparent path follows the input within the cycle.
        le_ab = 2'b11;
        a_in = 16'h1234; #1;
        chk("R1", b_out, 16'h1234);
        a_in = 16'h5a5a; #1;
        chk("R1", b_out, 16'h5a5a);

        // R9: the value at the last edge stays visible once the latch enable falls.
        @(posedge clk); #1;
        @(negedge clk);
        a_in = 16'h7777; le_ab = 2'b00; #1;
        chk("R9", b_out, 16'h5a5a);

        // R2: with the clock stopped, the latched output ignores input changes.
        clk_run = 1'b0;
        a_in = 16'h0f0f; #25;
        chk("R2", b_out, 16'h5a5a);
        a_in = 16'hf0f0; #25;
        chk("R2", b_out, 16'h5a5a);
        clk_run = 1'b1;

        // R3: the next rising edge captures the current input.
        @(posedge clk); #1;
        chk("R3", b_out, 16'hf0f0);

        // R7: only half 0 transparent; half 1 must hold.
        @(negedge clk);
        le_ab = 2'b01; a_in = 16'h3c96; #1;
        chk("R7", b_out, 16'hf096);
        oe_ab_n = 2'b10; #1;
        chk("R7", {14'h0, b_drv_en}, 16'h1);

        // R6: the global enable shuts every driver.
        oe_ab_n = 2'b00; oe_ba_n = 2'b00; oe_all_n = 1'b1; #1;
        chk("R6", {12'h0, b_drv_en, a_drv_en}, 16'h0);
        oe_all_n = 1'b0; #1;
        chk("R6", {12'h0, b_drv_en, a_drv_en}, 16'hf);

        // R5: B to A capture and transparency.
        @(negedge clk);
        le_ba = 2'b00; b_in = 16'hc001;
        @(posedge clk); #1;
        chk("R5", a_out, 16'hc001);
        @(negedge clk);
        le_ba = 2'b10; b_in = 16'h2233; #1;
        chk("R5", a_out, 16'h2201);

        // Random mix of data and controls, checked after each change and each edge.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            a_in = 16'($urandom); b_in = 16'($urandom);
            le_ab = 2'($urandom); le_ba = 2'($urandom);
            oe_ab_n = 2'($urandom); oe_ba_n = 2'($urandom);
            oe_all_n = ($urandom % 5) == 0;
            if (($urandom % 50) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            #1; check_all();
            @(posedge clk); #1; check_all();
        end

        $display("bus contention cycles seen: %0d", contention);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule